// File: doc/BRIEF.md
# DMA Stream Configuration Commit Engine

This block reprograms one stream of a multi-stream DMA controller as a single transaction. A request carries a packed request-source code (channel, owning controller and the set of streams allowed to serve it), the target stream index, the identity of the controller being programmed, the classes of the source and destination addresses, the two addresses, a transfer count, the element size on each side and a set of option flags.

When a request is accepted, the engine first runs the checks that need no register state. It then asks the stream to stop and waits until the stream's enable indication reads low. Next it pulses a clear of the stream's status flags. After that it builds a shadow copy of the stream's control word, count, peripheral address, memory address and FIFO word, and runs the checks that depend on the shadow. Only if every check passes is the shadow copied into the live register bank, all in one cycle. The result is reported as a status code that is valid during a one-cycle done pulse. The checks run in a fixed order and the first failure decides the code. The live registers can be read back at any time through a combinational read port.

The engine is a state machine with these states: IDLE (waiting; a valid request goes to PRECHK), PRECHK (a failure goes to REPLY, otherwise HALT), HALT (stop request held; leaves for CLEAR once the target stream's enable reads low), CLEAR (one-cycle flag clear, then BUILD), BUILD (shadow latched; a mode error goes to REPLY, otherwise VERIFY), VERIFY (a size or ratio error goes to REPLY, otherwise COMMIT), COMMIT (live write, then REPLY) and REPLY (done pulse, back to IDLE).

Top module: `strm_cfg_commit`

## Requirements
- R1: After reset the engine is idle (busy, done, stop_req and clr_flags low, status 0) and every live register of every stream reads 0.
- R2: The request-source code holds the channel in bits [2:0], the owning controller in bits [8:3] and the allowed-stream mask in bits [17:10]. If the mask bit of the target stream is clear, status is 1, and no stop request or flag clear is issued.
- R3: A transfer count above 65535 gives status 2. A count of exactly 65535 is legal.
- R4: If the owner field of the request-source code differs from ctrl_id, status is 3.
- R5: Address class encoding is 0 = memory, 1 = peripheral, 2 and 3 invalid. An invalid source class gives status 4 and an invalid destination class gives status 5.
- R6: Peripheral-to-peripheral gives status 6. Memory-to-memory gives status 6 unless ctrl_id equals the memory-capable controller identity (default 2).
- R7: Circular mode (flag bit 2) on a memory-to-memory transfer gives status 7.
- R8: If the peripheral size code is below the memory size code, the count must be a multiple of 2^(memory code − peripheral code); otherwise status is 8.
- R9: If the size codes differ and the FIFO-enable flag (bit 3) is clear, status is 9.
- R10: The checks are applied in the order R2, R3, R4, R5 (source before destination), R6, R7, R8, R9. The first failing check decides the status.
- R11: For a request that passes R2 through R6, stop_req stays high until stream_en of the target stream is sampled low. clr_flags then pulses for exactly one cycle. Each request gives exactly one one-cycle done pulse, and status is 0 whenever done is low.
- R12: On success (status 0) the stream's live registers are written as follows. The control word has channel at [27:25], priority [17:16] = 0, memory size at [14:13], peripheral size at [12:11], memory increment at bit 10, peripheral increment at bit 9, circular at bit 8, direction at [7:6] (0 = peripheral to memory, 1 = memory to peripheral, 2 = memory to memory), transfer-complete enable (flag 5) at bit 4 and error enable (flag 6) at bit 2. The count register holds the low 16 bits of the count. The FIFO word has FIFO enable at bit 2 and the FIFO error enable (flag 4) at bit 7. When the destination is memory, the source address, source size and source increment (flag 0) go to the peripheral side, and the destination values (flag 1) go to the memory side. When the destination is a peripheral, the two sides are swapped.
- R13: A request raised while busy is ignored. On any error status, the live registers of every stream are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only in IDLE |
| req_src | input | 18 | Request-source code (channel, owner, stream mask) |
| req_stream | input | 3 | Target stream index |
| ctrl_id | input | 6 | Identity of the controller being programmed |
| req_src_cls | input | 2 | Source address class |
| req_dst_cls | input | 2 | Destination address class |
| req_src_addr | input | 32 | Source address |
| req_dst_addr | input | 32 | Destination address |
| req_count | input | 17 | Transfer count |
| req_src_size | input | 2 | Source element size code (log2 bytes) |
| req_dst_size | input | 2 | Destination element size code (log2 bytes) |
| req_flags | input | 7 | Options: 0 src inc, 1 dst inc, 2 circular, 3 FIFO enable, 4 FIFO error enable, 5 complete enable, 6 error enable |
| stream_en | input | 8 | Enable indication of each stream |
| busy | output | 1 | Engine not idle |
| stop_req | output | 1 | Request to stop the target stream |
| stop_stream | output | 3 | Stream addressed by stop_req and clr_flags |
| clr_flags | output | 1 | One-cycle status flag clear |
| done | output | 1 | One-cycle completion pulse |
| status | output | 4 | Result code, valid with done |
| rd_stream | input | 3 | Live register read index |
| rd_ctrl | output | 32 | Live control word |
| rd_count | output | 16 | Live transfer count |
| rd_paddr | output | 32 | Live peripheral address |
| rd_maddr | output | 32 | Live memory address |
| rd_fifo | output | 8 | Live FIFO word |

## Verification
The main check is a sweep over every pair of source and destination classes, every pair of size codes up to 4 bytes, both FIFO and circular settings, counts of 12, 6 and 9, and both controller identities. This sweep separates the direction, mode, ratio and size outcomes, and also separates the two placements of addresses and sizes. Mixed into the sweep are requests with cleared stream mask bits, requests with a foreign owner, and streams that take a varying number of cycles to stop. These show that precheck failures never touch the stream and that the stop wait lasts exactly as long as the enable stays high. Directed cases cover requests that fail several checks at once (to confirm which check wins), the counts 65535 and 65536, and a second request raised while busy.

// File: rtl/strm_cfg_pkg.sv
package strm_cfg_pkg;

    // Request-source code layout
    localparam int CHAN_LSB   = 0;
    localparam int CHAN_W     = 3;
    localparam int OWNER_LSB  = 3;
    localparam int OWNER_W    = 6;
    localparam int MASK_LSB   = 10;

    // Register widths
    localparam int ADDR_W     = 32;
    localparam int CTRL_W     = 32;
    localparam int CNT_REG_W  = 16;
    localparam int FIFO_W     = 8;
    localparam int SIZE_W     = 2;
    localparam int CLS_W      = 2;

    // Control word fields
    localparam int CW_CHAN    = 25;
    localparam int CW_PRIO    = 16;
    localparam int CW_MSIZE   = 13;
    localparam int CW_PSIZE   = 11;
    localparam int CW_MINC    = 10;
    localparam int CW_PINC    = 9;
    localparam int CW_CIRC    = 8;
    localparam int CW_DIR     = 6;
    localparam int CW_TCIE    = 4;
    localparam int CW_TEIE    = 2;
    localparam logic [1:0] PRIO_LOW = 2'b00;

    // FIFO word fields
    localparam int FW_FIFO_EN = 2;
    localparam int FW_ERR_IE  = 7;

    // Request flag bits
    localparam int FL_SRC_INC = 0;
    localparam int FL_DST_INC = 1;
    localparam int FL_CIRC    = 2;
    localparam int FL_FIFO_EN = 3;
    localparam int FL_FERR_IE = 4;
    localparam int FL_TC_IE   = 5;
    localparam int FL_TE_IE   = 6;
    localparam int FLAG_W     = 7;

    localparam logic [CLS_W-1:0] CLS_MEM = 2'd0;
    localparam logic [CLS_W-1:0] CLS_PER = 2'd1;

    typedef enum logic [1:0] {
        DIR_P2M = 2'b00,
        DIR_M2P = 2'b01,
        DIR_M2M = 2'b10
    } dir_e;

    typedef enum logic [3:0] {
        ST_OK         = 4'd0,
        ST_BAD_STREAM = 4'd1,
        ST_BAD_COUNT  = 4'd2,
        ST_BAD_OWNER  = 4'd3,
        ST_BAD_SRC    = 4'd4,
        ST_BAD_DST    = 4'd5,
        ST_BAD_DIR    = 4'd6,
        ST_BAD_MODE   = 4'd7,
        ST_BAD_RATIO  = 4'd8,
        ST_BAD_SIZE   = 4'd9
    } status_e;

    typedef struct packed {
        logic [CTRL_W-1:0]    ctrl;
        logic [CNT_REG_W-1:0] count;
        logic [ADDR_W-1:0]    paddr;
        logic [ADDR_W-1:0]    maddr;
        logic [FIFO_W-1:0]    fifo;
    } stream_regs_t;

endpackage

// File: rtl/strm_cfg_precheck.sv
module strm_cfg_precheck
    import strm_cfg_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int SIDX_W      = 3,
    parameter int CNT_W       = 17,
    parameter int MAX_XFER    = 65535,
    parameter logic [OWNER_W-1:0] M2M_OWNER = 6'd2
) (
    input  logic [NUM_STREAMS-1:0] allowed_mask,
    input  logic [OWNER_W-1:0]     req_owner,
    input  logic [SIDX_W-1:0]      stream,
    input  logic [OWNER_W-1:0]     ctrl_id,
    input  logic [CLS_W-1:0]       src_cls,
    input  logic [CLS_W-1:0]       dst_cls,
    input  logic [CNT_W-1:0]       count,
    output status_e                err
);

    localparam logic [CNT_W-1:0] COUNT_LIMIT = CNT_W'(MAX_XFER);

    logic stream_ok;
    logic count_ok;
    logic owner_ok;
    logic src_ok;
    logic dst_ok;
    logic dir_ok;

    always_comb begin
        stream_ok = allowed_mask[stream];
        count_ok  = (count <= COUNT_LIMIT);
        owner_ok  = (req_owner == ctrl_id);
        src_ok    = (src_cls == CLS_MEM) || (src_cls == CLS_PER);
        dst_ok    = (dst_cls == CLS_MEM) || (dst_cls == CLS_PER);
        if (dst_cls == CLS_MEM) begin
            dir_ok = (src_cls == CLS_PER) || (ctrl_id == M2M_OWNER);
        end else begin
            dir_ok = (src_cls == CLS_MEM);
        end
    end

    always_comb begin
        if (!stream_ok) begin
            err = ST_BAD_STREAM;
        end else if (!count_ok) begin
            err = ST_BAD_COUNT;
        end else if (!owner_ok) begin
            err = ST_BAD_OWNER;
        end else if (!src_ok) begin
            err = ST_BAD_SRC;
        end else if (!dst_ok) begin
            err = ST_BAD_DST;
        end else if (!dir_ok) begin
            err = ST_BAD_DIR;
        end else begin
            err = ST_OK;
        end
    end

endmodule

// File: rtl/strm_cfg_shadow_build.sv
module strm_cfg_shadow_build
    import strm_cfg_pkg::*;
(
    input  logic [CHAN_W-1:0]    chan,
    input  logic [CLS_W-1:0]     src_cls,
    input  logic [CLS_W-1:0]     dst_cls,
    input  logic [ADDR_W-1:0]    src_addr,
    input  logic [ADDR_W-1:0]    dst_addr,
    input  logic [CNT_REG_W-1:0] count,
    input  logic [SIZE_W-1:0]    src_size,
    input  logic [SIZE_W-1:0]    dst_size,
    input  logic [FLAG_W-1:0]    flags,
    output stream_regs_t         shadow,
    output status_e              err
);

    logic              to_mem;
    dir_e              dir;
    logic [SIZE_W-1:0] per_size;
    logic [SIZE_W-1:0] mem_size;
    logic              per_inc;
    logic              mem_inc;
    logic [CTRL_W-1:0] ctrl;
    logic [FIFO_W-1:0] fifo;

    always_comb begin
        to_mem = (dst_cls == CLS_MEM);
        if (to_mem) begin
            dir = (src_cls == CLS_MEM) ? DIR_M2M : DIR_P2M;
        end else begin
            dir = DIR_M2P;
        end
        per_size = to_mem ? src_size : dst_size;
        mem_size = to_mem ? dst_size : src_size;
        per_inc  = to_mem ? flags[FL_SRC_INC] : flags[FL_DST_INC];
        mem_inc  = to_mem ? flags[FL_DST_INC] : flags[FL_SRC_INC];
    end

    always_comb begin
        ctrl                         = '0;
        ctrl[CW_CHAN +: CHAN_W]      = chan;
        ctrl[CW_PRIO +: 2]           = PRIO_LOW;
        ctrl[CW_MSIZE +: SIZE_W]     = mem_size;
        ctrl[CW_PSIZE +: SIZE_W]     = per_size;
        ctrl[CW_MINC]                = mem_inc;
        ctrl[CW_PINC]                = per_inc;
        ctrl[CW_CIRC]                = flags[FL_CIRC];
        ctrl[CW_DIR +: 2]            = dir;
        ctrl[CW_TCIE]                = flags[FL_TC_IE];
        ctrl[CW_TEIE]                = flags[FL_TE_IE];

        fifo                         = '0;
        fifo[FW_FIFO_EN]             = flags[FL_FIFO_EN];
        fifo[FW_ERR_IE]              = flags[FL_FERR_IE];

        shadow.ctrl  = ctrl;
        shadow.count = count;
        shadow.paddr = to_mem ? src_addr : dst_addr;
        shadow.maddr = to_mem ? dst_addr : src_addr;
        shadow.fifo  = fifo;

        err = ((dir == DIR_M2M) && flags[FL_CIRC]) ? ST_BAD_MODE : ST_OK;
    end

endmodule

// File: rtl/strm_cfg_postcheck.sv
module strm_cfg_postcheck
    import strm_cfg_pkg::*;
(
    input  logic [SIZE_W-1:0]    mem_size,
    input  logic [SIZE_W-1:0]    per_size,
    input  logic [CNT_REG_W-1:0] count,
    input  logic                 fifo_on,
    output status_e              err
);

    logic [CNT_REG_W-1:0] ratio_mask;
    logic                 narrow_per;

    always_comb begin
        narrow_per = (per_size < mem_size);
        ratio_mask = (CNT_REG_W'(1) << (mem_size - per_size)) - CNT_REG_W'(1);
        if (narrow_per && ((count & ratio_mask) != '0)) begin
            err = ST_BAD_RATIO;
        end else if ((mem_size != per_size) && !fifo_on) begin
            err = ST_BAD_SIZE;
        end else begin
            err = ST_OK;
        end
    end

endmodule

// File: rtl/strm_cfg_bank.sv
module strm_cfg_bank
    import strm_cfg_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int SIDX_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SIDX_W-1:0] widx,
    input  stream_regs_t      wdata,
    input  logic [SIDX_W-1:0] ridx,
    output stream_regs_t      rdata
);

    stream_regs_t live [NUM_STREAMS];

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
        stream_regs_t q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (widx == SIDX_W'(g))) begin
                q <= wdata;
            end
        end
        assign live[g] = q;
    end

    assign rdata = live[ridx];

endmodule

// File: rtl/strm_cfg_commit.sv
module strm_cfg_commit
    import strm_cfg_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int SIDX_W      = $clog2(NUM_STREAMS),
    parameter int CNT_W       = 17,
    parameter int MAX_XFER    = 65535,
    parameter logic [5:0] M2M_OWNER = 6'd2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [MASK_LSB+NUM_STREAMS-1:0] req_src,
    input  logic [SIDX_W-1:0]             req_stream,
    input  logic [5:0]                    ctrl_id,
    input  logic [1:0]                    req_src_cls,
    input  logic [1:0]                    req_dst_cls,
    input  logic [31:0]                   req_src_addr,
    input  logic [31:0]                   req_dst_addr,
    input  logic [CNT_W-1:0]              req_count,
    input  logic [1:0]                    req_src_size,
    input  logic [1:0]                    req_dst_size,
    input  logic [6:0]                    req_flags,
    input  logic [NUM_STREAMS-1:0]        stream_en,
    output logic                          busy,
    output logic                          stop_req,
    output logic [SIDX_W-1:0]             stop_stream,
    output logic                          clr_flags,
    output logic                          done,
    output logic [3:0]                    status,
    input  logic [SIDX_W-1:0]             rd_stream,
    output logic [31:0]                   rd_ctrl,
    output logic [15:0]                   rd_count,
    output logic [31:0]                   rd_paddr,
    output logic [31:0]                   rd_maddr,
    output logic [7:0]                    rd_fifo
);

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRECHK,
        S_HALT,
        S_CLEAR,
        S_BUILD,
        S_VERIFY,
        S_COMMIT,
        S_REPLY
    } state_e;

    state_e state_q;
    state_e state_d;

    // Latched request
    logic [NUM_STREAMS-1:0] mask_q;
    logic [OWNER_W-1:0]     owner_q;
    logic [CHAN_W-1:0]      chan_q;
    logic [SIDX_W-1:0]      stream_q;
    logic [OWNER_W-1:0]     ctrl_id_q;
    logic [CLS_W-1:0]       src_cls_q;
    logic [CLS_W-1:0]       dst_cls_q;
    logic [ADDR_W-1:0]      src_addr_q;
    logic [ADDR_W-1:0]      dst_addr_q;
    logic [CNT_W-1:0]       count_q;
    logic [SIZE_W-1:0]      src_size_q;
    logic [SIZE_W-1:0]      dst_size_q;
    logic [FLAG_W-1:0]      flags_q;

    status_e                err_q;
    stream_regs_t           shadow_q;

    status_e                pre_err;
    status_e                build_err;
    status_e                post_err;
    stream_regs_t           shadow_d;
    stream_regs_t           live_rd;

    logic                   accept;
    logic                   sel_en;
    logic                   bank_we;
    logic                   unused_bits;

    assign unused_bits = req_src[MASK_LSB-1];
    assign accept      = (state_q == S_IDLE) && req_valid;
    assign sel_en      = stream_en[stream_q];

    strm_cfg_precheck #(
        .NUM_STREAMS (NUM_STREAMS),
        .SIDX_W      (SIDX_W),
        .CNT_W       (CNT_W),
        .MAX_XFER    (MAX_XFER),
        .M2M_OWNER   (M2M_OWNER)
    ) u_precheck (
        .allowed_mask (mask_q),
        .req_owner    (owner_q),
        .stream       (stream_q),
        .ctrl_id      (ctrl_id_q),
        .src_cls      (src_cls_q),
        .dst_cls      (dst_cls_q),
        .count        (count_q),
        .err          (pre_err)
    );

    strm_cfg_shadow_build u_build (
        .chan     (chan_q),
        .src_cls  (src_cls_q),
        .dst_cls  (dst_cls_q),
        .src_addr (src_addr_q),
        .dst_addr (dst_addr_q),
        .count    (count_q[CNT_REG_W-1:0]),
        .src_size (src_size_q),
        .dst_size (dst_size_q),
        .flags    (flags_q),
        .shadow   (shadow_d),
        .err      (build_err)
    );

    strm_cfg_postcheck u_postcheck (
        .mem_size (shadow_q.ctrl[CW_MSIZE +: SIZE_W]),
        .per_size (shadow_q.ctrl[CW_PSIZE +: SIZE_W]),
        .count    (shadow_q.count),
        .fifo_on  (shadow_q.fifo[FW_FIFO_EN]),
        .err      (post_err)
    );

    strm_cfg_bank #(
        .NUM_STREAMS (NUM_STREAMS),
        .SIDX_W      (SIDX_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .widx  (stream_q),
        .wdata (shadow_q),
        .ridx  (rd_stream),
        .rdata (live_rd)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_PRECHK;
            S_PRECHK: state_d = (pre_err != ST_OK) ? S_REPLY : S_HALT;
            S_HALT:   if (!sel_en) state_d = S_CLEAR;
            S_CLEAR:  state_d = S_BUILD;
            S_BUILD:  state_d = (build_err != ST_OK) ? S_REPLY : S_VERIFY;
            S_VERIFY: state_d = (post_err != ST_OK) ? S_REPLY : S_COMMIT;
            S_COMMIT: state_d = S_REPLY;
            S_REPLY:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Request capture, shadow and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= '0;
            owner_q    <= '0;
            chan_q     <= '0;
            stream_q   <= '0;
            ctrl_id_q  <= '0;
            src_cls_q  <= '0;
            dst_cls_q  <= '0;
            src_addr_q <= '0;
            dst_addr_q <= '0;
            count_q    <= '0;
            src_size_q <= '0;
            dst_size_q <= '0;
            flags_q    <= '0;
            err_q      <= ST_OK;
            shadow_q   <= '0;
        end else begin
            if (accept) begin
                mask_q     <= req_src[MASK_LSB +: NUM_STREAMS];
                owner_q    <= req_src[OWNER_LSB +: OWNER_W];
                chan_q     <= req_src[CHAN_LSB +: CHAN_W];
                stream_q   <= req_stream;
                ctrl_id_q  <= ctrl_id;
                src_cls_q  <= req_src_cls;
                dst_cls_q  <= req_dst_cls;
                src_addr_q <= req_src_addr;
                dst_addr_q <= req_dst_addr;
                count_q    <= req_count;
                src_size_q <= req_src_size;
                dst_size_q <= req_dst_size;
                flags_q    <= req_flags;
                err_q      <= ST_OK;
            end
            if ((state_q == S_PRECHK) && (pre_err != ST_OK)) begin
                err_q <= pre_err;
            end
            if (state_q == S_BUILD) begin
                shadow_q <= shadow_d;
                if (build_err != ST_OK) begin
                    err_q <= build_err;
                end
            end
            if ((state_q == S_VERIFY) && (post_err != ST_OK)) begin
                err_q <= post_err;
            end
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q != S_IDLE);
        stop_req    = (state_q == S_HALT);
        clr_flags   = (state_q == S_CLEAR);
        bank_we     = (state_q == S_COMMIT);
        done        = (state_q == S_REPLY);
        status      = done ? err_q : ST_OK;
        stop_stream = stream_q;
        rd_ctrl     = live_rd.ctrl;
        rd_count    = live_rd.count;
        rd_paddr    = live_rd.paddr;
        rd_maddr    = live_rd.maddr;
        rd_fifo     = live_rd.fifo;
    end

endmodule

// File: rtl/strm_cfg_commit_chk.sv
module strm_cfg_commit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       stop_req,
    input logic       clr_flags,
    input logic       done,
    input logic [3:0] status,
    input logic       bank_we,
    input logic       sel_en
);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (status == 4'd0));

    // R11
    clear_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_flags |-> ($past(stop_req) && !$past(sel_en)));

    // R13
    commit_reports_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> (done && (status == 4'd0)));

    // R11
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stop_req, clr_flags, bank_we, done}));

    // R13
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

endmodule

bind strm_cfg_commit strm_cfg_commit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .stop_req  (stop_req),
    .clr_flags (clr_flags),
    .done      (done),
    .status    (status),
    .bank_we   (bank_we),
    .sel_en    (sel_en)
);

// File: tb/strm_cfg_commit_test.sv
`timescale 1ns/1ps
module strm_cfg_commit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [17:0] req_src = '0;
    logic [2:0]  req_stream = '0;
    logic [5:0]  ctrl_id = 6'd1;
    logic [1:0]  req_src_cls = '0;
    logic [1:0]  req_dst_cls = '0;
    logic [31:0] req_src_addr = '0;
    logic [31:0] req_dst_addr = '0;
    logic [16:0] req_count = '0;
    logic [1:0]  req_src_size = '0;
    logic [1:0]  req_dst_size = '0;
    logic [6:0]  req_flags = '0;
    logic [7:0]  stream_en = '0;
    logic        busy, stop_req, clr_flags, done;
    logic [2:0]  stop_stream;
    logic [3:0]  status;
    logic [2:0]  rd_stream = '0;
    logic [31:0] rd_ctrl, rd_paddr, rd_maddr;
    logic [15:0] rd_count;
    logic [7:0]  rd_fifo;

    always #2.5 clk = ~clk;

    strm_cfg_commit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_stream(req_stream), .ctrl_id(ctrl_id), .req_src_cls(req_src_cls),
        .req_dst_cls(req_dst_cls), .req_src_addr(req_src_addr),
        .req_dst_addr(req_dst_addr), .req_count(req_count),
        .req_src_size(req_src_size), .req_dst_size(req_dst_size),
        .req_flags(req_flags), .stream_en(stream_en), .busy(busy),
        .stop_req(stop_req), .stop_stream(stop_stream), .clr_flags(clr_flags),
        .done(done), .status(status), .rd_stream(rd_stream), .rd_ctrl(rd_ctrl),
        .rd_count(rd_count), .rd_paddr(rd_paddr), .rd_maddr(rd_maddr),
        .rd_fifo(rd_fifo)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Environment: stream enable that drops after a hold time under stop_req
    logic       arm = 1'b0;
    logic       arm_en = 1'b0;
    logic [2:0] arm_s = '0;
    int         arm_hold = 0;
    int         hold_cnt = 0;

    always @(posedge clk) begin
        if (arm) begin
            stream_en <= arm_en ? (8'd1 << arm_s) : 8'd0;
            hold_cnt  <= arm_hold;
        end else if (stop_req) begin
            if (hold_cnt != 0) hold_cnt <= hold_cnt - 1;
            else stream_en <= 8'd0;
        end
    end

    // Port monitor
    int tot_stop = 0, tot_clr = 0, tot_done = 0;
    logic [3:0] last_status = '0;
    always @(negedge clk) begin
        if (stop_req)  tot_stop <= tot_stop + 1;
        if (clr_flags) tot_clr  <= tot_clr + 1;
        if (done) begin
            tot_done    <= tot_done + 1;
            last_status <= status;
        end
    end

    // Model of the live registers
    logic [31:0] m_ctrl  [8];
    logic [15:0] m_count [8];
    logic [31:0] m_paddr [8];
    logic [31:0] m_maddr [8];
    logic [7:0]  m_fifo  [8];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd0: return "R12";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [3:0] exp_code(input logic [7:0] mask, input logic [5:0] owner,
            input int s, input logic [5:0] cid, input logic [1:0] sc, input logic [1:0] dc,
            input logic [16:0] cnt, input logic [1:0] ss, input logic [1:0] ds,
            input logic [6:0] fl);
        int p, m;
        if (!mask[s]) return 4'd1;
        if (cnt > 17'd65535) return 4'd2;
        if (owner != cid) return 4'd3;
        if (sc > 2'd1) return 4'd4;
        if (dc > 2'd1) return 4'd5;
        if (dc == 2'd1 && sc == 2'd1) return 4'd6;
        if (dc == 2'd0 && sc == 2'd0 && cid != 6'd2) return 4'd6;
        if (dc == 2'd0 && sc == 2'd0 && fl[2]) return 4'd7;
        if (dc == 2'd0) begin p = ss; m = ds; end
        else begin m = ss; p = ds; end
        if (p < m && (int'(cnt) % (1 << (m - p))) != 0) return 4'd8;
        if (m != p && !fl[3]) return 4'd9;
        return 4'd0;
    endfunction

    task automatic compare_regs(input int s, input string tag);
        rd_stream = 3'(s);
        #1;
        check(rd_ctrl  == m_ctrl[s],  tag, "ctrl",  rd_ctrl,  m_ctrl[s]);
        check(rd_count == m_count[s], tag, "count", rd_count, m_count[s]);
        check(rd_paddr == m_paddr[s], tag, "paddr", rd_paddr, m_paddr[s]);
        check(rd_maddr == m_maddr[s], tag, "maddr", rd_maddr, m_maddr[s]);
        check(rd_fifo  == m_fifo[s],  tag, "fifo",  rd_fifo,  m_fifo[s]);
    endtask

    task automatic run_txn(input logic [7:0] mask, input logic [5:0] owner,
            input logic [2:0] chan, input int s, input logic [5:0] cid,
            input logic [1:0] sc, input logic [1:0] dc, input logic [16:0] cnt,
            input logic [1:0] ss, input logic [1:0] ds, input logic [6:0] fl,
            input bit en0, input int hold, input bit intrude, input string force_tag);
        int d0, s0, c0, dir, p, m;
        logic [3:0] ec;
        bit pre_ok;
        logic [31:0] sa, da;
        string tg;
        sa = 32'h4000_0000 + 32'(s * 16) + 32'(cnt);
        da = 32'h2000_1000 ^ {8'h00, 1'b0, fl, 2'b00, ss, ds, sc, dc, 8'h5A};
        ec = exp_code(mask, owner, s, cid, sc, dc, cnt, ss, ds, fl);
        pre_ok = (ec == 4'd0) || (ec > 4'd6);
        tg = (force_tag != "") ? force_tag : tag_of(ec);

        @(negedge clk); #1;
        arm_s = 3'(s); arm_en = en0; arm_hold = hold; arm = 1'b1;
        @(negedge clk); #1;
        arm = 1'b0;
        req_src = {mask, 1'b0, owner, chan};
        req_stream = 3'(s); ctrl_id = cid;
        req_src_cls = sc; req_dst_cls = dc;
        req_src_addr = sa; req_dst_addr = da;
        req_count = cnt; req_src_size = ss; req_dst_size = ds; req_flags = fl;
        d0 = tot_done; s0 = tot_stop; c0 = tot_clr;
        req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        if (intrude) begin
            // R13: second request while busy, valid for another stream
            req_stream = 3'(s ^ 1);
            req_valid = 1'b1;
            repeat (3) begin @(negedge clk); #1; end
            req_valid = 1'b0;
        end
        while (tot_done == d0) begin @(negedge clk); #1; end
        repeat (3) begin @(negedge clk); #1; end

        check(last_status == ec, tg, "status", last_status, ec);
        check(tot_done - d0 == 1, "R11", "done pulses", tot_done - d0, 1);
        check(tot_clr - c0 == (pre_ok ? 1 : 0), "R11", "clear pulses", tot_clr - c0, pre_ok ? 1 : 0);
        check(tot_stop - s0 == (pre_ok ? (en0 ? hold + 2 : 1) : 0), "R11", "stop cycles",
              tot_stop - s0, pre_ok ? (en0 ? hold + 2 : 1) : 0);

        if (ec == 4'd0) begin
            if (dc == 2'd0) begin
                dir = (sc == 2'd0) ? 2 : 0;
                p = ss; m = ds;
                m_paddr[s] = sa; m_maddr[s] = da;
            end else begin
                dir = 1;
                m = ss; p = ds;
                m_maddr[s] = sa; m_paddr[s] = da;
            end
            m_ctrl[s] = (32'(chan) << 25) | (32'(m) << 13) | (32'(p) << 11)
                      | (32'(dc == 2'd0 ? fl[1] : fl[0]) << 10)
                      | (32'(dc == 2'd0 ? fl[0] : fl[1]) << 9)
                      | (32'(fl[2]) << 8) | (32'(dir) << 6)
                      | (32'(fl[5]) << 4) | (32'(fl[6]) << 2);
            m_count[s] = cnt[15:0];
            m_fifo[s]  = (8'(fl[3]) << 2) | (8'(fl[4]) << 7);
        end
        compare_regs(s, (ec == 4'd0) ? "R12" : "R13");
        if (intrude) compare_regs(s ^ 1, "R13");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_ctrl[i] = '0; m_count[i] = '0; m_paddr[i] = '0; m_maddr[i] = '0; m_fifo[i] = '0;
        end
        repeat (3) @(negedge clk);
        #1;
        check({busy, done, stop_req, clr_flags} == 4'b0, "R1", "idle outputs",
              {busy, done, stop_req, clr_flags}, 0);
        check(status == 4'd0, "R1", "status", status, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        for (int i = 0; i < 8; i++) compare_regs(i, "R1");

        // R10: several failures at once, first one wins
        run_txn(8'hFE, 6'd1, 3'd1, 0, 6'd1, 2'd1, 2'd0, 17'd70000, 2'd0, 2'd0, 7'h00, 1'b0, 0, 1'b0, "R10");
        run_txn(8'hFF, 6'd5, 3'd1, 1, 6'd1, 2'd1, 2'd0, 17'd70000, 2'd0, 2'd0, 7'h00, 1'b0, 0, 1'b0, "R10");
        run_txn(8'hFF, 6'd1, 3'd1, 2, 6'd1, 2'd3, 2'd2, 17'd8, 2'd0, 2'd0, 7'h00, 1'b0, 0, 1'b0, "R10");
        run_txn(8'hFF, 6'd1, 3'd1, 3, 6'd1, 2'd0, 2'd0, 17'd8, 2'd0, 2'd0, 7'h04, 1'b1, 1, 1'b0, "R10");
        run_txn(8'hFF, 6'd1, 3'd1, 4, 6'd1, 2'd1, 2'd0, 17'd9, 2'd0, 2'd2, 7'h00, 1'b1, 2, 1'b0, "R10");
        // R3: count boundary
        run_txn(8'hFF, 6'd1, 3'd6, 2, 6'd1, 2'd1, 2'd0, 17'd65535, 2'd1, 2'd1, 7'h23, 1'b1, 0, 1'b0, "R3");
        run_txn(8'hFF, 6'd1, 3'd6, 2, 6'd1, 2'd1, 2'd0, 17'd65536, 2'd1, 2'd1, 7'h23, 1'b0, 0, 1'b0, "R3");
        // R6: memory-to-memory on the capable controller
        run_txn(8'hFF, 6'd2, 3'd2, 7, 6'd2, 2'd0, 2'd0, 17'd40, 2'd2, 2'd0, 7'h4B, 1'b1, 3, 1'b0, "R6");
        // R13: request while busy is ignored
        run_txn(8'hFF, 6'd1, 3'd3, 5, 6'd1, 2'd0, 2'd1, 17'd100, 2'd2, 2'd2, 7'h61, 1'b1, 3, 1'b1, "R13");

        // Sweep
        begin
            int n = 0;
            for (int ci = 1; ci <= 2; ci++)
            for (int sc = 0; sc < 4; sc++)
            for (int dc = 0; dc < 4; dc++)
            for (int ss = 0; ss < 3; ss++)
            for (int ds = 0; ds < 3; ds++)
            for (int fv = 0; fv < 4; fv++)
            for (int ki = 0; ki < 3; ki++) begin
                int s;
                logic [7:0] mask;
                logic [5:0] owner;
                logic [16:0] cnt;
                logic [6:0] fl;
                s = n % 8;
                mask = (n % 5 == 0) ? ~(8'd1 << s) : 8'hFF;
                owner = (n % 7 == 3) ? (6'(ci) ^ 6'd3) : 6'(ci);
                cnt = (ki == 0) ? 17'd12 : (ki == 1) ? 17'd6 : 17'd9;
                fl = {n[3], n[2], n[4], fv[1], fv[0], n[1], n[0]};
                run_txn(mask, owner, 3'(n), s, 6'(ci), 2'(sc), 2'(dc), cnt,
                        2'(ss), 2'(ds), fl, (n % 3) != 0, n % 4, 1'b0, "");
                n++;
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule